// File: doc/BRIEF.md
# SPI NOR Region Erase Engine

This block erases a region of an external SPI NOR flash without processor involvement. A caller pulses `start` with a sector-aligned start address and a byte length. The engine then walks the region one sector at a time. For every sector it issues three kinds of framed transaction, each with its own chip-select window. The first is a write-enable. The second is the sector-erase command carrying the sector address. The third is a status read, repeated until the flash stops reporting write-in-progress. After each sector the engine pulses a progress strobe that carries the sector address. After the last sector it pulses `done`.

Requests are screened when `start` is accepted. An unaligned start, an unaligned length, or a region that reaches past the configured device size raises a sticky error flag. In that case no transaction is issued and the engine stays idle. A separate chip-wide mode sends write-enable, then the whole-device erase opcode, then polls status; it uses neither address nor length. Addresses go out in either a 3-byte or a 4-byte form. The form is chosen per request.

The engine does not shift bits itself. It hands complete transaction requests to a byte-level SPI master. Each request holds an opcode, an address with a byte count, and an optional one-byte read. The master answers each accepted request with `rsp_valid` once chip select has been released. States: `ST_IDLE`, `ST_WREN_REQ`, `ST_WREN_WAIT`, `ST_ERASE_REQ`, `ST_ERASE_WAIT`, `ST_POLL_REQ`, `ST_POLL_WAIT`, `ST_SECTOR_END`. Transitions:
- IDLE to WREN_REQ on an accepted request.
- Each REQ state to its WAIT state on `cmd_ready`.
- WREN_WAIT to ERASE_REQ on `rsp_valid`.
- ERASE_WAIT to POLL_REQ on `rsp_valid`.
- POLL_WAIT back to POLL_REQ while busy. When not busy, it goes to SECTOR_END, or to IDLE in chip mode.
- SECTOR_END to WREN_REQ for the next sector, or to IDLE after the last one.

Top module: `spi_erase_seq`

## Requirements
- R1: With `chip_mode` low, a start address whose low `SEC_LOG2` bits are not all zero sets `err_align_addr`. No transaction is issued and `done` stays low. This check has the highest priority.
- R2: With an aligned start address, a length whose low `SEC_LOG2` bits are not all zero sets `err_align_len` only. No transaction is issued.
- R3: For an aligned request, if the start address is at or above `DEV_BYTES`, or start plus length exceeds `DEV_BYTES`, `err_range` is set alone. No transaction is issued.
- R4: Each sector begins with a write-enable transaction, then an erase transaction. The write-enable has opcode 0x06, address length 0 and no read. The erase has opcode 0x20 and carries the sector address.
- R5: With `addr_4b` high, the erase transaction has `cmd_addr_len` = 4 and the full address. With it low, it has `cmd_addr_len` = 3 and bits 31:24 of `cmd_addr` are zero, so only the low 24 bits go out.
- R6: After each erase, status reads follow. Each has opcode 0x05, address length 0 and `cmd_rd_byte` = 1. They repeat while bit 0 of the returned byte is 1. No other transaction is issued before a read returns bit 0 = 0.
- R7: Sectors are handled in ascending order: start, start+2^SEC_LOG2, and so on. A one-cycle `progress_valid` with `progress_addr` set to the sector address follows each sector's final status read.
- R8: `done` pulses for one cycle, in the cycle after the last sector's progress pulse. A zero-length aligned request pulses `done` with no transaction.
- R9: With `chip_mode` high, the engine issues write-enable, then opcode 0xC7 with address length 0, then status reads as in R6. It then pulses `done`, with no progress pulse. Address and length are not checked.
- R10: Error flags are mutually exclusive and stay set until the next accepted `start`, which clears them. While a flag is set, no transaction is requested.
- R11: A request holds its `cmd_valid` and fields stable until `cmd_ready`. No new request is raised between acceptance and `rsp_valid`.
- R12: After reset the engine is idle. `busy`, `cmd_valid`, `done`, `progress_valid` and all error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, taken only when idle |
| chip_mode | input | 1 | 1: whole-device erase; 0: region erase |
| addr_4b | input | 1 | 1: 4-byte address form; 0: 3-byte form |
| start_addr | input | ADDR_W | Region start byte address |
| length | input | ADDR_W | Region length in bytes |
| busy | output | 1 | Engine is working on a request |
| cmd_valid | output | 1 | Transaction request to SPI master |
| cmd_ready | input | 1 | Master accepts the request |
| cmd_op | output | 8 | Opcode byte |
| cmd_addr | output | ADDR_W | Address, sent MSB first over `cmd_addr_len` bytes |
| cmd_addr_len | output | 3 | Address bytes: 0, 3 or 4 |
| cmd_rd_byte | output | 1 | 1: read one byte after the header |
| rsp_valid | input | 1 | Transaction finished, chip select released |
| rsp_data | input | 8 | Byte read during the transaction |
| progress_valid | output | 1 | One-cycle pulse per finished sector |
| progress_addr | output | ADDR_W | Address of the finished sector |
| done | output | 1 | One-cycle pulse at completion |
| err_align_addr | output | 1 | Sticky start-address alignment error |
| err_align_len | output | 1 | Sticky length alignment error |
| err_range | output | 1 | Sticky out-of-range error |

## Verification
The hardest case to reach from the ports is a multi-sector region where different sectors stay busy for different numbers of status reads. It must run while the master's acceptance and completion latencies vary, because only that mix shows whether a poll loop ever leaks into the next sector's write-enable. The flash responder in the bench draws a fresh busy count and latency for every erase. The bench records each transaction the engine issues and the busy count it handed out. It then rebuilds the expected command stream from the request. Regions above 16 MiB are driven in both address forms to expose truncation of the top byte.

// File: rtl/spi_erase_pkg.sv
package spi_erase_pkg;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_SE   = 8'h20;
    localparam logic [7:0] OP_CE   = 8'hC7;
    localparam logic [7:0] OP_RDSR = 8'h05;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WREN_REQ,
        ST_WREN_WAIT,
        ST_ERASE_REQ,
        ST_ERASE_WAIT,
        ST_POLL_REQ,
        ST_POLL_WAIT,
        ST_SECTOR_END
    } seq_state_e;

    typedef enum logic [1:0] {
        CK_WREN,
        CK_ERASE,
        CK_CHIP,
        CK_POLL
    } cmd_kind_e;

    typedef enum logic [1:0] {
        RQ_OK,
        RQ_BAD_ADDR,
        RQ_BAD_LEN,
        RQ_RANGE
    } req_verdict_e;

endpackage

// File: rtl/spi_erase_reqchk.sv
module spi_erase_reqchk
    import spi_erase_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 32,
    parameter int unsigned       SEC_LOG2  = 12,
    parameter longint unsigned   DEV_BYTES = 64'h200_0000
) (
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] length,
    output req_verdict_e      verdict
);

    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(DEV_BYTES);

    logic [ADDR_W:0] end_addr;
    assign end_addr = {1'b0, start_addr} + {1'b0, length};

    always_comb begin
        if (|start_addr[SEC_LOG2-1:0]) begin
            verdict = RQ_BAD_ADDR;
        end else if (|length[SEC_LOG2-1:0]) begin
            verdict = RQ_BAD_LEN;
        end else if (({1'b0, start_addr} >= LIMIT) || (end_addr > LIMIT)) begin
            verdict = RQ_RANGE;
        end else begin
            verdict = RQ_OK;
        end
    end

endmodule

// File: rtl/spi_erase_walker.sv
module spi_erase_walker #(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned SEC_LOG2 = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load,
    input  logic                         step,
    input  logic [ADDR_W-1:0]            base,
    input  logic [ADDR_W-SEC_LOG2-1:0]   sec_count,
    output logic [ADDR_W-1:0]            sec_addr,
    output logic                         last
);

    localparam int unsigned      CNT_W     = ADDR_W - SEC_LOG2 + 1;
    localparam logic [ADDR_W-1:0] SEC_BYTES = ADDR_W'(1) << SEC_LOG2;
    localparam logic [CNT_W-1:0]  CNT_ONE   = CNT_W'(1);

    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_addr <= '0;
            left_q   <= '0;
        end else if (load) begin
            sec_addr <= base;
            left_q   <= {1'b0, sec_count};
        end else if (step) begin
            sec_addr <= sec_addr + SEC_BYTES;
            left_q   <= left_q - CNT_ONE;
        end
    end

    assign last = (left_q == CNT_ONE);

endmodule

// File: rtl/spi_erase_cmdfmt.sv
module spi_erase_cmdfmt
    import spi_erase_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  cmd_kind_e         kind,
    input  logic              addr4b,
    input  logic [ADDR_W-1:0] sec_addr,
    output logic [7:0]        op,
    output logic [ADDR_W-1:0] addr,
    output logic [2:0]        addr_len,
    output logic              rd_byte
);

    logic [ADDR_W-1:0] low3;

    generate
        if (ADDR_W > 24) begin : g_trim
            assign low3 = {{(ADDR_W-24){1'b0}}, sec_addr[23:0]};
        end else begin : g_pass
            assign low3 = sec_addr;
        end
    endgenerate

    always_comb begin
        op       = OP_WREN;
        addr     = '0;
        addr_len = 3'd0;
        rd_byte  = 1'b0;
        unique case (kind)
            CK_WREN: op = OP_WREN;
            CK_ERASE: begin
                op       = OP_SE;
                addr     = addr4b ? sec_addr : low3;
                addr_len = addr4b ? 3'd4 : 3'd3;
            end
            CK_CHIP: op = OP_CE;
            CK_POLL: begin
                op      = OP_RDSR;
                rd_byte = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/spi_erase_seq.sv
module spi_erase_seq
    import spi_erase_pkg::*;
#(
    parameter int unsigned     ADDR_W    = 32,
    parameter int unsigned     SEC_LOG2  = 12,
    parameter longint unsigned DEV_BYTES = 64'h200_0000,
    parameter logic [7:0]      BUSY_MASK = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              chip_mode,
    input  logic              addr_4b,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] length,
    output logic              busy,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [7:0]        cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [2:0]        cmd_addr_len,
    output logic              cmd_rd_byte,
    input  logic              rsp_valid,
    input  logic [7:0]        rsp_data,
    output logic              progress_valid,
    output logic [ADDR_W-1:0] progress_addr,
    output logic              done,
    output logic              err_align_addr,
    output logic              err_align_len,
    output logic              err_range
);

    seq_state_e   state_q, state_d;
    req_verdict_e verdict;
    cmd_kind_e    kind;
    logic         chip_q, a4_q;
    logic         flash_busy;
    logic         accept, load, step, last;
    logic [ADDR_W-1:0] sec_addr;

    spi_erase_reqchk #(
        .ADDR_W(ADDR_W), .SEC_LOG2(SEC_LOG2), .DEV_BYTES(DEV_BYTES)
    ) u_reqchk (
        .start_addr(start_addr),
        .length    (length),
        .verdict   (verdict)
    );

    spi_erase_walker #(
        .ADDR_W(ADDR_W), .SEC_LOG2(SEC_LOG2)
    ) u_walker (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .base     (start_addr),
        .sec_count(length[ADDR_W-1:SEC_LOG2]),
        .sec_addr (sec_addr),
        .last     (last)
    );

    spi_erase_cmdfmt #(
        .ADDR_W(ADDR_W)
    ) u_cmdfmt (
        .kind    (kind),
        .addr4b  (a4_q),
        .sec_addr(sec_addr),
        .op      (cmd_op),
        .addr    (cmd_addr),
        .addr_len(cmd_addr_len),
        .rd_byte (cmd_rd_byte)
    );

    assign accept     = (state_q == ST_IDLE) && start;
    assign load       = accept && !chip_mode;
    assign step       = (state_q == ST_SECTOR_END) && !last;
    assign flash_busy = |(rsp_data & BUSY_MASK);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (chip_mode) begin
                        state_d = ST_WREN_REQ;
                    end else if ((verdict == RQ_OK) &&
                                 (|length[ADDR_W-1:SEC_LOG2])) begin
                        state_d = ST_WREN_REQ;
                    end
                end
            end
            ST_WREN_REQ:   if (cmd_ready) state_d = ST_WREN_WAIT;
            ST_WREN_WAIT:  if (rsp_valid) state_d = ST_ERASE_REQ;
            ST_ERASE_REQ:  if (cmd_ready) state_d = ST_ERASE_WAIT;
            ST_ERASE_WAIT: if (rsp_valid) state_d = ST_POLL_REQ;
            ST_POLL_REQ:   if (cmd_ready) state_d = ST_POLL_WAIT;
            ST_POLL_WAIT: begin
                if (rsp_valid) begin
                    if (flash_busy)  state_d = ST_POLL_REQ;
                    else if (chip_q) state_d = ST_IDLE;
                    else             state_d = ST_SECTOR_END;
                end
            end
            ST_SECTOR_END: state_d = last ? ST_IDLE : ST_WREN_REQ;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            chip_q  <= 1'b0;
            a4_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                chip_q <= chip_mode;
                a4_q   <= addr_4b;
            end
        end
    end

    // combinational outputs
    always_comb begin
        kind      = CK_WREN;
        cmd_valid = 1'b0;
        unique case (state_q)
            ST_WREN_REQ: begin
                kind      = CK_WREN;
                cmd_valid = 1'b1;
            end
            ST_ERASE_REQ: begin
                kind      = chip_q ? CK_CHIP : CK_ERASE;
                cmd_valid = 1'b1;
            end
            ST_POLL_REQ: begin
                kind      = CK_POLL;
                cmd_valid = 1'b1;
            end
            default: begin
                kind      = CK_WREN;
                cmd_valid = 1'b0;
            end
        endcase
    end

    assign busy = (state_q != ST_IDLE);

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            progress_valid <= 1'b0;
            progress_addr  <= '0;
            done           <= 1'b0;
            err_align_addr <= 1'b0;
            err_align_len  <= 1'b0;
            err_range      <= 1'b0;
        end else begin
            progress_valid <= 1'b0;
            done           <= 1'b0;
            if (accept) begin
                err_align_addr <= 1'b0;
                err_align_len  <= 1'b0;
                err_range      <= 1'b0;
                if (!chip_mode) begin
                    unique case (verdict)
                        RQ_BAD_ADDR: err_align_addr <= 1'b1;
                        RQ_BAD_LEN:  err_align_len  <= 1'b1;
                        RQ_RANGE:    err_range      <= 1'b1;
                        RQ_OK:       done <= ~|length[ADDR_W-1:SEC_LOG2];
                    endcase
                end
            end
            if ((state_q == ST_POLL_WAIT) && rsp_valid && !flash_busy) begin
                if (chip_q) begin
                    done <= 1'b1;
                end else begin
                    progress_valid <= 1'b1;
                    progress_addr  <= sec_addr;
                end
            end
            if ((state_q == ST_SECTOR_END) && last) begin
                done <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/spi_erase_seq_chk.sv
module spi_erase_seq_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [7:0]        cmd_op,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [2:0]        cmd_addr_len,
    input logic              cmd_rd_byte,
    input logic              rsp_valid,
    input logic              progress_valid,
    input logic              done,
    input logic              err_align_addr,
    input logic              err_align_len,
    input logic              err_range
);

    logic in_flight;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      in_flight <= 1'b0;
        else if (cmd_valid && cmd_ready) in_flight <= 1'b1;
        else if (rsp_valid)              in_flight <= 1'b0;
    end

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) &&
        $stable(cmd_addr) && $stable(cmd_addr_len) && $stable(cmd_rd_byte));

    a_r11_single: assert property (@(posedge clk) disable iff (!rst_n)
        in_flight |-> !cmd_valid);

    a_r5_low_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (cmd_addr_len == 3'd3) |-> (cmd_addr >> 24) == '0);

    a_r4_wren_form: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (cmd_op == 8'h06) |-> (cmd_addr_len == 3'd0) && !cmd_rd_byte);

    a_r6_poll_form: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (cmd_op == 8'h05) |-> (cmd_addr_len == 3'd0) && cmd_rd_byte);

    a_r7_progress_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        progress_valid |=> !progress_valid);

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_one_err: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_align_addr, err_align_len, err_range}));

    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (err_align_addr || err_align_len || err_range) |-> !cmd_valid);

endmodule

bind spi_erase_seq spi_erase_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .cmd_op        (cmd_op),
    .cmd_addr      (cmd_addr),
    .cmd_addr_len  (cmd_addr_len),
    .cmd_rd_byte   (cmd_rd_byte),
    .rsp_valid     (rsp_valid),
    .progress_valid(progress_valid),
    .done          (done),
    .err_align_addr(err_align_addr),
    .err_align_len (err_align_len),
    .err_range     (err_range)
);

// File: tb/spi_erase_seq_tb_top.sv
module spi_erase_seq_tb_top;

    localparam int unsigned ADDR_W = 32;
    localparam logic [31:0] SEC    = 32'h1000;
    localparam logic [31:0] DEV    = 32'h200_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, chip_mode = 1'b0, addr_4b = 1'b0;
    logic [31:0] start_addr = '0, length = '0;
    logic busy, cmd_valid, cmd_rd_byte;
    logic cmd_ready = 1'b0, rsp_valid = 1'b0;
    logic [7:0] cmd_op;
    logic [7:0] rsp_data = 8'h00;
    logic [31:0] cmd_addr, progress_addr;
    logic [2:0] cmd_addr_len;
    logic progress_valid, done, err_align_addr, err_align_len, err_range;

    always #4 clk = ~clk;

    spi_erase_seq #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .chip_mode(chip_mode),
        .addr_4b(addr_4b), .start_addr(start_addr), .length(length),
        .busy(busy), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_addr_len(cmd_addr_len),
        .cmd_rd_byte(cmd_rd_byte), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .progress_valid(progress_valid), .progress_addr(progress_addr),
        .done(done), .err_align_addr(err_align_addr),
        .err_align_len(err_align_len), .err_range(err_range)
    );

    int nchk = 0, nerr = 0;
    logic [7:0]  log_op   [256];
    logic [31:0] log_addr [256];
    logic [2:0]  log_alen [256];
    logic        log_rd   [256];
    int          busy_log [64];
    logic [31:0] prog_log [64];
    int n_cmd = 0, n_erase = 0, n_prog = 0, n_done = 0;
    int busy_left = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // flash responder standing in for the byte-level master
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && cmd_valid) begin
                log_op[n_cmd] = cmd_op;
                log_addr[n_cmd] = cmd_addr;
                log_alen[n_cmd] = cmd_addr_len;
                log_rd[n_cmd] = cmd_rd_byte;
                n_cmd++;
                if (cmd_op == 8'h20 || cmd_op == 8'hC7) begin
                    busy_left = int'($urandom % 4);
                    busy_log[n_erase] = busy_left;
                    n_erase++;
                end
                cmd_ready = 1'b1;
                @(negedge clk);
                cmd_ready = 1'b0;
                repeat (1 + $urandom % 3) @(negedge clk);
                rsp_data = 8'h00;
                if (log_op[n_cmd-1] == 8'h05) begin
                    if (busy_left > 0) begin
                        rsp_data = 8'h03;
                        busy_left--;
                    end else begin
                        rsp_data = 8'h02;
                    end
                end
                rsp_valid = 1'b1;
                @(negedge clk);
                rsp_valid = 1'b0;
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (progress_valid) begin
                prog_log[n_prog] = progress_addr;
                n_prog++;
            end
            if (done) n_done++;
        end
    end

    function automatic logic [31:0] wire_addr(input logic [31:0] a, input bit a4);
        return a4 ? a : {8'h00, a[23:0]};
    endfunction

    task automatic run_op(input bit chip, input bit a4, input logic [31:0] sa,
                          input logic [31:0] len);
        n_cmd = 0; n_erase = 0; n_prog = 0; n_done = 0;
        @(negedge clk);
        chip_mode = chip; addr_4b = a4; start_addr = sa; length = len; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            if (n_done > 0 || err_align_addr || err_align_len || err_range) break;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic check_polls(inout int j, input int e, input string tag);
        for (int p = 0; p <= busy_log[e]; p++) begin
            check(log_op[j] == 8'h05 && log_rd[j] && log_alen[j] == 3'd0,
                  tag, {24'h0, log_op[j]}, 32'h05);
            j++;
        end
    endtask

    task automatic check_region(input logic [31:0] sa, input int nsec, input bit a4,
                                input string tag);
        int j = 0;
        run_op(1'b0, a4, sa, SEC * nsec);
        for (int s = 0; s < nsec; s++) begin
            logic [31:0] a = sa + SEC * s;
            check(log_op[j] == 8'h06 && log_alen[j] == 3'd0 && !log_rd[j],
                  {tag, " R4 wren"}, {24'h0, log_op[j]}, 32'h06);
            j++;
            check(log_op[j] == 8'h20, {tag, " R4 erase op"}, {24'h0, log_op[j]}, 32'h20);
            check(log_addr[j] == wire_addr(a, a4), {tag, " R5 erase addr"},
                  log_addr[j], wire_addr(a, a4));
            check(log_alen[j] == (a4 ? 3'd4 : 3'd3), {tag, " R5 addr len"},
                  {29'h0, log_alen[j]}, a4 ? 32'd4 : 32'd3);
            j++;
            check_polls(j, s, {tag, " R6 poll"});
            check(prog_log[s] == a, {tag, " R7 progress addr"}, prog_log[s], a);
        end
        check(n_cmd == j, {tag, " R6 transaction count"}, n_cmd, j);
        check(n_prog == nsec, {tag, " R7 progress count"}, n_prog, nsec);
        check(n_done == 1, {tag, " R8 done count"}, n_done, 1);
    endtask

    task automatic check_error(input logic [31:0] sa, input logic [31:0] len,
                               input logic [2:0] exp_flags, input string tag);
        run_op(1'b0, 1'b0, sa, len);
        check({err_align_addr, err_align_len, err_range} == exp_flags, tag,
              {29'h0, err_align_addr, err_align_len, err_range}, {29'h0, exp_flags});
        check(n_cmd == 0 && n_done == 0, {tag, " no bus activity"}, n_cmd, 0);
        repeat (20) @(negedge clk);
        check({err_align_addr, err_align_len, err_range} == exp_flags && !busy,
              "R10 sticky flag", {29'h0, err_align_addr, err_align_len, err_range},
              {29'h0, exp_flags});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        int sd;
        sd = int'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check(!busy && !cmd_valid && !done && !progress_valid &&
              !err_align_addr && !err_align_len && !err_range,
              "R12 reset state", {31'h0, busy}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        check_region(32'h0000_1000, 3, 1'b0, "directed 3b");
        check_region(32'h0180_0000, 2, 1'b1, "high 4b");
        check_region(32'h0180_0000, 2, 1'b0, "high 3b");
        check_region(DEV - SEC, 1, 1'b1, "last sector");

        check_error(32'h0000_1234, 32'h1000, 3'b100, "R1 addr align");
        check_region(32'h0000_4000, 1, 1'b0, "R10 clear after start");
        check(!err_align_addr, "R10 flag cleared", {31'h0, err_align_addr}, 32'h0);
        check_error(32'h0000_0010, 32'h0000_0010, 3'b100, "R1 priority");
        check_error(32'h0000_2000, 32'h0000_1800, 3'b010, "R2 len align");
        check_error(DEV - SEC, SEC * 2, 3'b001, "R3 end past size");
        check_error(DEV, 32'h0, 3'b001, "R3 start at size");

        run_op(1'b0, 1'b0, 32'h0000_8000, 32'h0);
        check(n_cmd == 0 && n_done == 1 && !err_range, "R8 zero length",
              n_cmd, 0);

        begin
            int j = 0;
            run_op(1'b1, 1'b0, 32'h0000_0123, 32'h0000_0007);
            check(log_op[0] == 8'h06, "R9 chip wren", {24'h0, log_op[0]}, 32'h06);
            check(log_op[1] == 8'hC7 && log_alen[1] == 3'd0, "R9 chip opcode",
                  {24'h0, log_op[1]}, 32'hC7);
            j = 2;
            check_polls(j, 0, "R9 chip poll");
            check(n_cmd == j && n_prog == 0 && n_done == 1 && !err_align_addr,
                  "R9 chip totals", n_cmd, j);
        end

        for (int it = 0; it < 12; it++) begin
            int nsec = 1 + int'($urandom % 4);
            logic [31:0] idx = $urandom % (DEV / SEC - 4);
            check_region(idx * SEC, nsec, bit'($urandom % 2), "random R4 R7");
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule